// File: doc/BRIEF.md
# Serial Frame Exchange Core

This block sits at the centre of a synchronous serial port. Software-facing logic pushes outgoing frames into an eight-entry transmit queue and pops incoming frames from an eight-entry receive queue. While the port is switched on, the core takes the oldest outgoing frame, trims it to the configured frame width and hands it to an external serialiser through a request/acknowledge exchange. The frame that the serialiser returns is trimmed the same way and appended to the receive queue.

The core never lets the receive queue overflow. A new exchange starts only when the receive queue has a free slot, so the slot is effectively reserved before the serialiser is asked to shift. When the receive queue is full, outgoing frames wait in the transmit queue. In internal loopback the serialiser is left idle and the trimmed outgoing frame goes straight into the receive queue in a single cycle.

Top module: `sspx_xfer_core`

## Requirements
- R1: After reset both queues are empty: `tx_empty`=1, `tx_not_full`=1, `rx_not_empty`=0, `rx_full`=0, `busy`=0 and `xch_req`=0.
- R2: While `port_en` is 0, no new exchange starts. No frame leaves the transmit queue, `xch_req` stays 0 and nothing enters the receive queue. Pushes are still accepted and the status outputs keep following the queue contents.
- R3: An exchange starts only when the transmit queue is not empty and the receive queue holds fewer than 8 frames. When the receive queue is full, the core waits and drops no frame.
- R4: Frames leave the receive queue in the order in which their transmit frames were pushed. Each queue holds exactly 8 frames, and its indices wrap from 7 back to 0.
- R5: When an exchange starts in normal mode, `xch_req` rises one clock after the start, with the trimmed frame on `xch_tdata`. Both stay unchanged until a cycle in which `xch_ack` is 1. At that clock edge `xch_rdata` is captured and `xch_req` falls.
- R6: With `loop_en`=1 when an exchange starts, the trimmed transmit frame is written into the receive queue at that same clock edge and `xch_req` does not rise.
- R7: Each stored frame and each frame driven on `xch_tdata` is ANDed with a mask whose low n bits are 1. n is `frame_bits` clamped to the range 4 to 16. A returned frame uses the mask that was in force when its exchange started.
- R8: A push while the transmit queue holds 8 frames is dropped, even if a pop happens in the same cycle. A pop while the receive queue is empty does nothing.
- R9: `tx_empty`, `tx_not_full`, `rx_not_empty` and `rx_full` reflect the queue counts after the last clock edge. `busy` is 1 while an exchange is in flight or the transmit queue is not empty.
- R10: An exchange already in flight when `port_en` falls still completes, and its returned frame is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Allows new exchanges to start |
| loop_en | input | 1 | Internal loopback instead of the serialiser |
| frame_bits | input | 5 | Frame width in bits, clamped to 4..16 |
| tx_push | input | 1 | Push `tx_wdata` into the transmit queue |
| tx_wdata | input | 16 | Frame to push |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_rdata | output | 16 | Head of the receive queue, valid while `rx_not_empty` |
| xch_req | output | 1 | Exchange request to the serialiser |
| xch_tdata | output | 16 | Frame to shift out |
| xch_ack | input | 1 | Serialiser finished; `xch_rdata` is valid |
| xch_rdata | input | 16 | Frame shifted in |
| tx_empty | output | 1 | Transmit queue empty |
| tx_not_full | output | 1 | Transmit queue has room |
| rx_not_empty | output | 1 | Receive queue holds data |
| rx_full | output | 1 | Receive queue holds 8 frames |
| busy | output | 1 | Exchange in flight or frames waiting to go |

## Verification
Exchanges are tried in five patterns. The first fills the transmit queue while the port is off and then lets it drain into a receive queue nobody reads, which separates a correct stall from a lost or overwritten frame. Loopback with a frame width below the minimum checks the clamp and the single-cycle path. Normal exchanges at frame widths of 5 and of 20 check the trim on both directions. A long random mix then varies serialiser latency, push and pop rates, enable, loopback and frame width on every cycle, which exposes ordering and index-wrap faults and faults on simultaneous push and pop at a full or empty queue. A behavioural queue model is compared with every output at every clock.

// File: rtl/sspx_pkg.sv
package sspx_pkg;

    // Smallest frame the core will exchange; narrower settings are raised to this.
    localparam int unsigned MIN_FRAME_BITS = 4;

    typedef enum logic {
        XS_IDLE = 1'b0,
        XS_WAIT = 1'b1
    } xfer_st_e;

    // Clamp a requested width into [MIN_FRAME_BITS, max_bits].
    function automatic int unsigned clamp_bits(input int unsigned req, input int unsigned max_bits);
        int unsigned n;
        n = req;
        if (n < MIN_FRAME_BITS) n = MIN_FRAME_BITS;
        if (n > max_bits)       n = max_bits;
        return n;
    endfunction

endpackage

// File: rtl/sspx_fifo.sv
module sspx_fifo #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count
);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop  && (st_q.cnt != '0);
        if (do_push) st_d.wr = bump(st_q.wr);
        if (do_pop)  st_d.rd = bump(st_q.rd);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wr] <= wdata;
    end

    assign rdata = mem[st_q.rd];
    assign count = st_q.cnt;

    // R8: a push into a full queue without a pop leaves it full
    a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && st_q.cnt == CW'(DEPTH)) |=> (st_q.cnt == CW'(DEPTH)));

    // R8: a pop from an empty queue without a push leaves it empty
    a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && st_q.cnt == '0) |=> (st_q.cnt == '0));

    // R4: write index wraps to zero after the last slot
    a_r4_wr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (push && st_q.cnt != CW'(DEPTH) && st_q.wr == AW'(DEPTH - 1)) |=> (st_q.wr == '0));

    // R4: read index wraps to zero after the last slot
    a_r4_rd_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && st_q.cnt != '0 && st_q.rd == AW'(DEPTH - 1)) |=> (st_q.rd == '0));

endmodule

// File: rtl/sspx_xfer_ctrl.sv
module sspx_xfer_ctrl
    import sspx_pkg::*;
#(
    parameter int unsigned FW  = 16,
    localparam int unsigned SZW = $clog2(FW + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           port_en,
    input  logic           loop_en,
    input  logic [SZW-1:0] frame_bits,
    input  logic           tx_have,
    input  logic [FW-1:0]  tx_head,
    output logic           tx_pop,
    input  logic           rx_room,
    output logic           rx_push,
    output logic [FW-1:0]  rx_wdata,
    output logic           xch_req,
    output logic [FW-1:0]  xch_tdata,
    input  logic           xch_ack,
    input  logic [FW-1:0]  xch_rdata,
    output logic           in_flight
);

    typedef struct packed {
        xfer_st_e      st;
        logic [FW-1:0] data;
        logic [FW-1:0] mask;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic [FW-1:0] cur_mask;
    logic          can_start;

    // Mask with the low n bits set, n being the clamped frame width.
    always_comb begin
        int unsigned n;
        n = clamp_bits(int'(frame_bits), FW);
        for (int i = 0; i < int'(FW); i++) begin
            cur_mask[i] = (i < int'(n));
        end
    end

    always_comb begin
        st_d      = st_q;
        tx_pop    = 1'b0;
        rx_push   = 1'b0;
        rx_wdata  = '0;
        can_start = port_en && tx_have && rx_room;
        case (st_q.st)
            XS_IDLE: begin
                if (can_start) begin
                    tx_pop = 1'b1;
                    if (loop_en) begin
                        rx_push  = 1'b1;
                        rx_wdata = tx_head & cur_mask;
                    end else begin
                        st_d.st   = XS_WAIT;
                        st_d.data = tx_head & cur_mask;
                        st_d.mask = cur_mask;
                    end
                end
            end
            XS_WAIT: begin
                if (xch_ack) begin
                    rx_push  = 1'b1;
                    rx_wdata = xch_rdata & st_q.mask;
                    st_d.st  = XS_IDLE;
                end
            end
            default: st_d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: XS_IDLE, data: '0, mask: '0};
        else        st_q <= st_d;
    end

    assign xch_req   = (st_q.st == XS_WAIT);
    assign xch_tdata = st_q.data;
    assign in_flight = (st_q.st == XS_WAIT);

    // R5: request and outgoing frame hold until acknowledged
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xch_req && !xch_ack) |=> (xch_req && $stable(xch_tdata)));

    // R5: acknowledge ends the request
    a_r5_ack_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (xch_req && xch_ack) |=> !xch_req);

    // R2: disabled idle engine takes nothing from the transmit queue
    a_r2_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en && st_q.st == XS_IDLE) |-> !tx_pop);

    // R3: never write into a full receive queue from idle
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_room && st_q.st == XS_IDLE) |-> !rx_push);

    // R6: loopback never raises a request
    a_r6_loop_local: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && st_q.st == XS_IDLE) |=> !xch_req);

endmodule

// File: rtl/sspx_xfer_core.sv
module sspx_xfer_core
    import sspx_pkg::*;
#(
    parameter int unsigned FRAME_W    = 16,
    parameter int unsigned FIFO_DEPTH = 8,
    localparam int unsigned SZ_W  = $clog2(FRAME_W + 1),
    localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               port_en,
    input  logic               loop_en,
    input  logic [SZ_W-1:0]    frame_bits,
    input  logic               tx_push,
    input  logic [FRAME_W-1:0] tx_wdata,
    input  logic               rx_pop,
    output logic [FRAME_W-1:0] rx_rdata,
    output logic               xch_req,
    output logic [FRAME_W-1:0] xch_tdata,
    input  logic               xch_ack,
    input  logic [FRAME_W-1:0] xch_rdata,
    output logic               tx_empty,
    output logic               tx_not_full,
    output logic               rx_not_empty,
    output logic               rx_full,
    output logic               busy
);

    logic [CNT_W-1:0]   tx_cnt, rx_cnt;
    logic [FRAME_W-1:0] tx_head, rx_wdata;
    logic               tx_pop, rx_push, in_flight;

    sspx_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .wdata (tx_wdata),
        .pop   (tx_pop),
        .rdata (tx_head),
        .count (tx_cnt)
    );

    sspx_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_wdata),
        .pop   (rx_pop),
        .rdata (rx_rdata),
        .count (rx_cnt)
    );

    sspx_xfer_ctrl #(.FW(FRAME_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_en    (port_en),
        .loop_en    (loop_en),
        .frame_bits (frame_bits),
        .tx_have    (tx_cnt != '0),
        .tx_head    (tx_head),
        .tx_pop     (tx_pop),
        .rx_room    (rx_cnt != CNT_W'(FIFO_DEPTH)),
        .rx_push    (rx_push),
        .rx_wdata   (rx_wdata),
        .xch_req    (xch_req),
        .xch_tdata  (xch_tdata),
        .xch_ack    (xch_ack),
        .xch_rdata  (xch_rdata),
        .in_flight  (in_flight)
    );

    assign tx_empty     = (tx_cnt == '0);
    assign tx_not_full  = (tx_cnt != CNT_W'(FIFO_DEPTH));
    assign rx_not_empty = (rx_cnt != '0);
    assign rx_full      = (rx_cnt == CNT_W'(FIFO_DEPTH));
    assign busy         = in_flight || !tx_empty;

    // R3: the receive count never moves past full between edges
    a_r3_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |=> (rx_cnt == CNT_W'(FIFO_DEPTH) || rx_cnt == CNT_W'(FIFO_DEPTH - 1)));

    // R9: a request on the link implies the core reports busy
    a_r9_busy_req: assert property (@(posedge clk) disable iff (!rst_n)
        xch_req |-> busy);

endmodule

// File: tb/sspx_xfer_core_tb.sv
module sspx_xfer_core_tb;

    localparam logic [15:0] KEY = 16'h5A3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0, loop_en = 1'b0;
    logic [4:0]  frame_bits = 5'd16;
    logic        tx_push = 1'b0, rx_pop = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic        xch_ack = 1'b0;
    logic [15:0] xch_rdata = '0;
    logic [15:0] rx_rdata, xch_tdata;
    logic        xch_req, tx_empty, tx_not_full, rx_not_empty, rx_full, busy;

    int checks = 0, errors = 0, lat = 0, wcnt = 0;

    always #5 clk = ~clk;

    sspx_xfer_core u_dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .loop_en(loop_en),
        .frame_bits(frame_bits), .tx_push(tx_push), .tx_wdata(tx_wdata),
        .rx_pop(rx_pop), .rx_rdata(rx_rdata), .xch_req(xch_req),
        .xch_tdata(xch_tdata), .xch_ack(xch_ack), .xch_rdata(xch_rdata),
        .tx_empty(tx_empty), .tx_not_full(tx_not_full),
        .rx_not_empty(rx_not_empty), .rx_full(rx_full), .busy(busy)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [15:0] bmask(input int req);
        int n;
        n = req;
        if (n < 4)  n = 4;
        if (n > 16) n = 16;
        return 16'((32'h1 << n) - 1);
    endfunction

    // Behavioural reference: two queues and an in-flight slot
    logic [15:0] m_tx[$];
    logic [15:0] m_rx[$];
    bit          m_wait = 0;
    logic [15:0] m_fly = '0, m_fmask = '0;

    always @(posedge clk) begin
        int tc, rc;
        logic [15:0] d;
        if (!rst_n) begin
            m_tx.delete(); m_rx.delete(); m_wait = 0;
        end else begin
            tc = m_tx.size();
            rc = m_rx.size();
            if (rx_pop && rc > 0) void'(m_rx.pop_front());
            if (!m_wait) begin
                if (port_en && tc > 0 && rc < 8) begin
                    d = m_tx.pop_front();
                    if (loop_en) m_rx.push_back(d & bmask(int'(frame_bits)));
                    else begin
                        m_wait  = 1;
                        m_fly   = d & bmask(int'(frame_bits));
                        m_fmask = bmask(int'(frame_bits));
                    end
                end
            end else if (xch_ack) begin
                m_rx.push_back(xch_rdata & m_fmask);
                m_wait = 0;
            end
            if (tx_push && tc < 8) m_tx.push_back(tx_wdata);
        end
    end

    // Every-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9 tx_empty",     16'(tx_empty),     16'(m_tx.size() == 0));
            chk("R8 R9 tx_not_full", 16'(tx_not_full), 16'(m_tx.size() < 8));
            chk("R9 rx_not_empty", 16'(rx_not_empty), 16'(m_rx.size() > 0));
            chk("R3 R9 rx_full",   16'(rx_full),      16'(m_rx.size() == 8));
            chk("R9 busy",         16'(busy),         16'(m_wait || m_tx.size() > 0));
            chk("R5 xch_req",      16'(xch_req),      16'(m_wait));
            if (m_wait)          chk("R5 R7 xch_tdata", xch_tdata, m_fly);
            if (m_rx.size() > 0) chk("R4 R7 rx_rdata",  rx_rdata,  m_rx[0]);
        end
    end

    // Serialiser stand-in: answer after lat idle cycles with a keyed frame
    always @(negedge clk) begin
        if (xch_ack) xch_ack <= 1'b0;
        else if (xch_req) begin
            if (wcnt >= lat) begin
                xch_ack   <= 1'b1;
                xch_rdata <= xch_tdata ^ KEY;
                wcnt      <= 0;
            end else wcnt <= wcnt + 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [15:0] v);
        tx_push = 1'b1; tx_wdata = v;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic drain();
        rx_pop = 1'b1;
        tick(80);
        rx_pop = 1'b0;
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        tick(4);
        chk("R1 tx_empty", 16'(tx_empty), 16'd1);
        chk("R1 tx_not_full", 16'(tx_not_full), 16'd1);
        chk("R1 rx_not_empty", 16'(rx_not_empty), 16'd0);
        chk("R1 rx_full", 16'(rx_full), 16'd0);
        chk("R1 busy", 16'(busy), 16'd0);
        chk("R1 xch_req", 16'(xch_req), 16'd0);
        rst_n = 1'b1;
        tick(2);

        // Disabled: fill past capacity, nothing moves
        for (int i = 0; i < 10; i++) push(16'h1000 + 16'(i));
        tick(5);
        chk("R8 push dropped when full", 16'(tx_not_full), 16'd0);
        chk("R2 no request", 16'(xch_req), 16'd0);
        chk("R2 rx stays empty", 16'(rx_not_empty), 16'd0);
        chk("R2 R9 busy while queued", 16'(busy), 16'd1);
        rx_pop = 1'b1; tick(2); rx_pop = 1'b0;
        chk("R8 pop on empty", 16'(rx_not_empty), 16'd0);

        // Enabled with nobody reading: receive queue fills, then stall
        lat = 2; port_en = 1'b1;
        for (int i = 0; i < 200 && !rx_full; i++) tick(1);
        for (int i = 0; i < 3; i++) push(16'h2000 + 16'(i));
        tick(8);
        chk("R3 stall no request", 16'(xch_req), 16'd0);
        chk("R3 rx held full", 16'(rx_full), 16'd1);
        chk("R3 tx kept", 16'(tx_empty), 16'd0);
        drain();
        chk("R4 all drained rx", 16'(rx_not_empty), 16'd0);
        chk("R4 all drained tx", 16'(tx_empty), 16'd1);

        // Loopback with a width below the minimum
        loop_en = 1'b1; frame_bits = 5'd2;
        push(16'hA5F7); push(16'h1238); push(16'hFFFF); push(16'h0004);
        for (int i = 0; i < 6; i++) begin
            chk("R6 no request in loopback", 16'(xch_req), 16'd0);
            tick(1);
        end
        chk("R6 R7 clamped loopback frame", rx_rdata, 16'h0007);
        drain();

        // Width above the maximum, normal exchange
        loop_en = 1'b0; frame_bits = 5'd20; lat = 1;
        push(16'hBEEF);
        tick(8);
        chk("R7 wide clamp", rx_rdata, 16'hE4D3);
        drain();

        // Narrow frame
        frame_bits = 5'd5; lat = 0;
        push(16'h00FF);
        tick(6);
        chk("R7 narrow frame", rx_rdata, 16'h0003);
        drain();

        // Disable while a frame is in flight
        frame_bits = 5'd16; lat = 6;
        push(16'h1234);
        for (int i = 0; i < 20 && !xch_req; i++) tick(1);
        port_en = 1'b0;
        tick(12);
        chk("R10 in-flight completes", 16'(rx_not_empty), 16'd1);
        chk("R10 returned frame", rx_rdata, 16'h4808);
        chk("R10 request ended", 16'(xch_req), 16'd0);
        drain();

        // Random mix
        for (int c = 0; c < 3000; c++) begin
            tx_push  = ($urandom % 2) == 0;
            tx_wdata = 16'($urandom);
            rx_pop   = ($urandom % 3) == 0;
            port_en  = ($urandom % 10) != 0;
            if (($urandom % 40) == 0) loop_en = ~loop_en;
            if (($urandom % 50) == 0) frame_bits = 5'($urandom % 32);
            if (($urandom % 60) == 0) lat = int'($urandom % 4);
            tick(1);
        end
        tx_push = 1'b0; port_en = 1'b1;
        tick(60);
        drain();
        chk("R4 final tx empty", 16'(tx_empty), 16'd1);
        chk("R4 final rx empty", 16'(rx_not_empty), 16'd0);
        report();
    end

endmodule